// File: doc/BRIEF.md
# I2C Target with Byte-Level Clock Stretching

This block is the target (slave) side of an I2C bus, run from a fast system clock that oversamples the open-drain SCL and SDA lines. It recognises START and STOP conditions and compares each transfer's first byte against a 7-bit own address. That address is kept in register 0 of a small internal register file, so a bus write can change it. Write transfers load a register pointer and then fill consecutive registers. Read transfers return registers from the pointer onward, most significant bit first.

Every byte the target receives, address bytes included, is presented for processing before the acknowledge slot. While the byte waits, the target holds SCL low. The local logic finishes the byte by pulsing `byte_done`. The target then drives the ACK onto SDA and releases SCL one system cycle later. A controller that honours clock stretching needs no fixed delays: it only has to see SCL high again before it goes on.

Hand-off rules for the byte interface: `rx_valid` rises only while SCL is being held. `rx_data` and `rx_is_addr` stay stable until `byte_done` is seen. A `byte_done` pulse while `rx_valid` is low is ignored. Because the bus stays stalled, there is no limit on how long the local logic can hold off. The system clock must run at least eight times faster than SCL, and `NREGS` must be a power of two.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `rx_valid` are all low, and the own address is 7'h4B.
- R2: A first byte whose upper seven bits equal the own address is acknowledged (SDA low in the ninth clock). Bit 0 of that byte selects the direction: 0 is a controller write and 1 is a controller read. For address 7'h4B these bytes are 8'h96 and 8'h97. For address 7'h01 they are 8'h02 and 8'h03.
- R3: During the stall, `rx_data` holds the received byte and `rx_is_addr` is 1 only for the address byte.
- R4: After the eighth bit of a received byte, the target holds SCL low (`scl_oe` high) for as long as `rx_valid` is high, and for no other reason.
- R5: On the cycle after `byte_done` is sampled with `rx_valid` high, `sda_oe` is high (ACK) while `scl_oe` is still high. One cycle later `scl_oe` is low.
- R6: In a write transfer, the first data byte sets the register pointer from its low bits. Each later byte writes the register at the pointer, and the pointer then increments.
- R7: In a read transfer, the target sends the register at the pointer MSB-first, changes SDA only while SCL is low, and increments the pointer after each byte.
- R8: A NAK from the controller after a read byte ends the read: SDA stays released until the next START.
- R9: A non-matching address byte causes no stretch and no ACK. Both lines stay released until the next START.
- R10: Writing register 0 sets the own address to bits 6:0 of the written byte. Matching uses the new address from then on, and the old address gets NAK.
- R11: A START at any point, repeated or not, restarts address reception with both lines released. A partial byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (at least 8x the SCL rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| rx_valid | output | 1 | Received byte waiting for processing, bus stalled |
| rx_data | output | 8 | Received byte |
| rx_is_addr | output | 1 | Waiting byte is the address byte |
| byte_done | input | 1 | One-cycle pulse: byte processed, release the bus |

## Verification
The embedded properties check the following on every cycle: the stall is held exactly while a byte waits, the release runs in order (ACK first, then SCL), a START returns the target to a released idle reception, SDA is never newly pulled low while SCL is high, and the lines stay released while a transfer is being ignored. Other behaviour shows only in the bench scenarios. These include register contents written and read back through the bus, pointer auto-increment across transfers, runtime address reprogramming with the old address refused, and a repeated START that cuts a data byte short. The bench's controller model measures the stretch length, and a per-clock monitor flags any pull on SCL outside an acknowledge slot.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_STALL,
    S_ACKSET,
    S_ACK,
    S_WRX,
    S_TX,
    S_TXACK,
    S_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level,
  output logic rise,
  output logic fall
);
  // idle bus is high, so reset to ones to avoid spurious edges
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], line_i};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int         NREGS      = 8,
  parameter int         DW         = 8,
  parameter logic [6:0] RESET_ADDR = 7'h4B,
  localparam int        PW         = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [6:0]    own_addr
);
  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      mem[0] <= DW'(RESET_ADDR);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata    = mem[raddr];
  assign own_addr = mem[0][6:0];
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
  import i2c_tgt_pkg::*;
#(
  parameter int         NREGS       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] RESET_ADDR  = 7'h4B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_is_addr,
  input  logic       byte_done
);
  localparam int PW = $clog2(NREGS);

  logic scl_s, scl_r, scl_f, sda_s, sda_r, sda_f;
  logic start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level(scl_s), .rise(scl_r), .fall(scl_f));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level(sda_s), .rise(sda_r), .fall(sda_f));

  assign start_det = scl_s & sda_f;
  assign stop_det  = scl_s & sda_r;

  tgt_state_e    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          is_addr, first_data, rd_dir, ctl_nak;
  logic [PW-1:0] ptr;
  logic          scl_oe_q, sda_oe_q;
  logic          rf_we;
  logic [7:0]    rf_rdata;
  logic [6:0]    own_addr;
  logic          done_ok;

  assign done_ok = (state == S_STALL) && byte_done;
  assign rf_we   = done_ok && !is_addr && !first_data;

  i2c_regfile #(.NREGS(NREGS), .DW(8), .RESET_ADDR(RESET_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rf_rdata), .own_addr(own_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      is_addr    <= 1'b0;
      first_data <= 1'b0;
      rd_dir     <= 1'b0;
      ctl_nak    <= 1'b0;
      ptr        <= '0;
      scl_oe_q   <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else if (start_det) begin
      state    <= S_ADDR;
      bit_cnt  <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      bit_cnt  <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_SKIP: ;
        S_ADDR, S_WRX: begin
          if (scl_r && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_f && bit_cnt == 4'd8) begin
            if (state == S_ADDR && shreg[7:1] != own_addr) begin
              state <= S_SKIP;
            end else begin
              scl_oe_q <= 1'b1;
              is_addr  <= (state == S_ADDR);
              if (state == S_ADDR) rd_dir <= shreg[0];
              state    <= S_STALL;
            end
          end
        end
        S_STALL: begin
          if (byte_done) begin
            sda_oe_q <= 1'b1;
            if (is_addr) begin
              first_data <= 1'b1;
            end else if (first_data) begin
              ptr        <= shreg[PW-1:0];
              first_data <= 1'b0;
            end else begin
              ptr <= ptr + 1'b1;
            end
            state <= S_ACKSET;
          end
        end
        S_ACKSET: begin
          scl_oe_q <= 1'b0;
          state    <= S_ACK;
        end
        S_ACK: begin
          if (scl_f) begin
            bit_cnt <= '0;
            if (is_addr && rd_dir) begin
              shreg    <= rf_rdata;
              sda_oe_q <= ~rf_rdata[7];
              state    <= S_TX;
            end else begin
              sda_oe_q <= 1'b0;
              state    <= S_WRX;
            end
          end
        end
        S_TX: begin
          if (scl_r) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_f) begin
            if (bit_cnt == 4'd8) begin
              sda_oe_q <= 1'b0;
              ptr      <= ptr + 1'b1;
              state    <= S_TXACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_oe_q <= ~shreg[6];
            end
          end
        end
        S_TXACK: begin
          if (scl_r) begin
            ctl_nak <= sda_s;
          end else if (scl_f) begin
            if (ctl_nak) begin
              state <= S_SKIP;
            end else begin
              bit_cnt  <= '0;
              shreg    <= rf_rdata;
              sda_oe_q <= ~rf_rdata[7];
              state    <= S_TX;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign scl_oe     = scl_oe_q;
  assign sda_oe     = sda_oe_q;
  assign rx_valid   = (state == S_STALL);
  assign rx_data    = shreg;
  assign rx_is_addr = is_addr;

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> scl_oe);

  // R5
  ack_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && byte_done) |=> (sda_oe && scl_oe));

  // R5
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && byte_done) |=> ##1 !scl_oe);

  // R7
  sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> (!scl_oe && !sda_oe));

  // R11
  start_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_ADDR && !scl_oe && !sda_oe));
endmodule

// File: tb/i2c_stretch_target_tb.sv
module i2c_stretch_target_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ctl_scl_low = 1'b0, ctl_sda_low = 1'b0;
  logic scl_oe, sda_oe, rx_valid, rx_is_addr;
  logic [7:0] rx_data;
  logic byte_done = 1'b0;
  wire scl_line = !(ctl_scl_low || scl_oe);
  wire sda_line = !(ctl_sda_low || sda_oe);

  i2c_stretch_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_is_addr(rx_is_addr), .byte_done(byte_done));

  int checks = 0, errors = 0;
  int done_delay = 20;
  logic [7:0] last_rx;
  logic last_is_addr;
  logic ack_slot = 1'b0, skip_win = 1'b0;
  int mon_bad = 0;
  bit finished = 0;

  // behavioural reference: register contents, pointer, own address
  logic [7:0] mregs [8];
  int mptr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high(output int n);
    n = 0;
    while (!scl_line) begin @(negedge clk); n++; end
  endtask

  task automatic send_bit(input bit b);
    int n;
    ctl_sda_low = !b;
    wcyc(6);
    ctl_scl_low = 1'b0;
    wait_scl_high(n);
    wcyc(10);
    ctl_scl_low = 1'b1;
  endtask

  task automatic recv_bit(output bit b);
    int n;
    ctl_sda_low = 1'b0;
    wcyc(6);
    ctl_scl_low = 1'b0;
    wait_scl_high(n);
    wcyc(5);
    b = sda_line;
    wcyc(5);
    ctl_scl_low = 1'b1;
  endtask

  task automatic write_byte(input logic [7:0] d, output bit nak, output int st);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    ack_slot = 1'b1;
    ctl_sda_low = 1'b0;
    wcyc(6);
    ctl_scl_low = 1'b0;
    wait_scl_high(st);
    wcyc(5);
    nak = sda_line;
    wcyc(5);
    ctl_scl_low = 1'b1;
    ack_slot = 1'b0;
  endtask

  task automatic read_byte(input bit send_nak, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(send_nak);
  endtask

  task automatic start_c();
    ctl_sda_low = 1'b1; wcyc(10); ctl_scl_low = 1'b1; wcyc(6);
  endtask

  task automatic rstart_c();
    int n;
    ctl_sda_low = 1'b0; wcyc(6); ctl_scl_low = 1'b0;
    wait_scl_high(n); wcyc(10);
    ctl_sda_low = 1'b1; wcyc(10); ctl_scl_low = 1'b1; wcyc(6);
  endtask

  task automatic stop_c();
    int n;
    ctl_sda_low = 1'b1; wcyc(6); ctl_scl_low = 1'b0;
    wait_scl_high(n); wcyc(10);
    ctl_sda_low = 1'b0; wcyc(10);
  endtask

  task automatic finish_sim();
    if (finished) return;
    finished = 1;
    chk(mon_bad == 0, "R4/R9 monitor", mon_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // byte processing responder, also checks release order (R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        last_rx = rx_data;
        last_is_addr = rx_is_addr;
        wcyc(done_delay);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        chk(sda_oe && scl_oe, "R5 ack before release", {sda_oe, scl_oe}, 2'b11);
        @(negedge clk);
        chk(sda_oe && !scl_oe, "R5 scl released", {sda_oe, scl_oe}, 2'b10);
      end
    end
  end

  // per-clock reference comparison: SCL pulled only inside an ACK slot,
  // nothing driven during an ignored transfer
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe && !ack_slot) mon_bad++;
      if (skip_win && (scl_oe || sda_oe)) mon_bad++;
      if (rx_valid && !scl_oe) mon_bad++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    bit nak;
    int st;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) mregs[i] = 8'h00;
    mregs[0] = 8'h4B;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(3);
    // R1 reset state
    chk(!scl_oe && !sda_oe && !rx_valid, "R1 reset outputs", {scl_oe, sda_oe, rx_valid}, 0);

    // write transfer: pointer 1, data 5A, A5
    start_c();
    write_byte(8'h96, nak, st);
    chk(!nak, "R2 address 4B write ack", nak, 0);
    chk(last_rx == 8'h96 && last_is_addr, "R3 address byte on rx", {last_is_addr, last_rx}, 9'h196);
    chk(st >= 12, "R4 stretch length", st, 12);
    write_byte(8'h01, nak, st);
    chk(!nak && !last_is_addr && last_rx == 8'h01, "R3 pointer byte", last_rx, 1);
    mptr = 1;
    done_delay = 3;
    write_byte(8'h5A, nak, st);
    mregs[mptr] = 8'h5A; mptr++;
    write_byte(8'hA5, nak, st);
    mregs[mptr] = 8'hA5; mptr++;
    chk(!nak, "R6 data byte ack", nak, 0);
    stop_c();

    // set pointer, repeated START, read two bytes
    start_c();
    write_byte(8'h96, nak, st);
    write_byte(8'h01, nak, st);
    mptr = 1;
    rstart_c();
    write_byte(8'h97, nak, st);
    chk(!nak, "R2 address 4B read ack", nak, 0);
    read_byte(1'b0, d);
    chk(d == mregs[mptr], "R6 R7 read reg1", d, mregs[mptr]); mptr++;
    read_byte(1'b1, d);
    chk(d == mregs[mptr], "R7 read reg2", d, mregs[mptr]); mptr++;
    wcyc(8);
    chk(!sda_oe, "R8 sda released after nak", sda_oe, 0);
    ctl_sda_low = 1'b0; wcyc(6); ctl_scl_low = 1'b0; wcyc(12);
    chk(!sda_oe && sda_line, "R8 no drive in next clock", sda_oe, 0);
    ctl_scl_low = 1'b1; wcyc(6);
    stop_c();

    // non-matching address
    start_c();
    skip_win = 1'b1;
    write_byte(8'h44, nak, st);
    chk(nak, "R9 mismatch nak", nak, 1);
    chk(st <= 2, "R9 no stretch", st, 2);
    write_byte(8'h00, nak, st);
    chk(nak, "R9 data ignored", nak, 1);
    stop_c();
    skip_win = 1'b0;

    // reprogram own address to 01
    start_c();
    write_byte(8'h96, nak, st);
    write_byte(8'h00, nak, st);
    write_byte(8'h01, nak, st);
    mregs[0] = 8'h01; mptr = 1;
    stop_c();
    start_c();
    skip_win = 1'b1;
    write_byte(8'h96, nak, st);
    chk(nak, "R10 old address refused", nak, 1);
    stop_c();
    skip_win = 1'b0;
    start_c();
    write_byte(8'h02, nak, st);
    chk(!nak, "R10 new address 01 ack", nak, 0);

    // repeated START cuts a data byte short
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    rstart_c();
    chk(!scl_oe && !sda_oe, "R11 lines released after start", {scl_oe, sda_oe}, 0);
    write_byte(8'h03, nak, st);
    chk(!nak, "R11 address after restart", nak, 0);
    read_byte(1'b1, d);
    chk(d == mregs[mptr], "R11 read after restart", d, mregs[mptr]);
    stop_c();
    wcyc(10);
    finish_sim();
  end
endmodule